// File: doc/BRIEF.md
# Keyboard Matrix Scan Sequencer

This block walks a 16-column by 6-row keyboard matrix, one key position at a time, and reports the state of the selected key to a per-key state machine further down the line. A free-running 12-bit counter advances once per clock. Its upper four bits choose the column, which is driven by a one-hot, active-high column bus. Its next three bits choose a row input. Its lowest five bits divide each key slot into 32 clock phases. The 7-bit scancode shown to the consumer is the column and row-select fields joined, column in the upper bits.

Every column has eight row-select slots, and only six of them carry real rows. Slots 0 and 1 come first after each column change and are marked invalid. This gives externally filtered row lines time to settle before the first real row is read. The row inputs pass through a two-stage synchroniser and are sampled once per slot, late in the slot. Each valid slot also gives a read strobe early on and a write strobe after the sample, so the consumer can fetch its stored state for that key and then write it back. A force-open input makes every sample read as released. Holding it high for at least one full scan lets the downstream logic resynchronise.

All outputs are plain timing and control signals. The scan never stalls and there is no back-pressure. The consumer must finish its read-modify-write within the slot that the strobes frame.

Top module: `keyscan_seq`

## Requirements
- R1: While synchronous reset is high, the counter is cleared at each clock edge and the sampled key state clears to 0. After reset the scancode is 0, column 0 alone is driven, and the key output is 0.
- R2: The counter advances by one on every clock that is not in reset. It wraps from 4095 to 0, giving a full scan of 4096 clocks. scancode_o equals counter bits [11:5], which is {column[3:0], row-select[2:0]}.
- R3: Exactly one bit of col_o is high at any time. col_o[c] is high when scancode_o[6:3] equals c, and it changes only when the counter's low 8 bits wrap.
- R4: slot_valid_o is high when the row-select field scancode_o[2:0] is between 2 and 7. It is low for row-select 0 and 1. Neither strobe is ever given in an invalid slot.
- R5: rd_stb_o is high for exactly one clock per valid slot, in slot phase 1 (counter bits [4:0] equal 1).
- R6: wr_stb_o is high for exactly one clock per valid slot, in slot phase 30. It is never high in the same clock as rd_stb_o.
- R7: At the clock edge that ends slot phase 28, key_o loads rows_i[row-select − 2], taken through a two-stage synchroniser. key_o holds that value until the next such edge, with 1 meaning closed. An invalid slot loads 0.
- R8: If force_open_i is high at the sampling edge, key_o loads 0 whatever the row inputs are.
- R9: While wr_stb_o is high, key_o is the state of the key named by the scancode_o shown in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_i | input | 1 | Synchronous active-high reset |
| force_open_i | input | 1 | Forces every sample to read as released |
| rows_i | input | 6 | Conditioned row levels; bit k is the row at row-select k+2 |
| col_o | output | 16 | One-hot active-high column drive |
| scancode_o | output | 7 | {column, row-select} of the current slot |
| slot_valid_o | output | 1 | Current slot addresses a real row |
| rd_stb_o | output | 1 | Read-phase strobe for the per-key state machine |
| wr_stb_o | output | 1 | Write-phase strobe for the per-key state machine |
| key_o | output | 1 | Sampled key state, 1 = closed |

## Verification
The scancode, column drive, slot valid and both strobes are decoded from the counter without further registers. Each is therefore due in the same clock as the counter value it belongs to. The bench keeps its own counter that steps at every rising edge and compares all of these outputs at the following falling edge. key_o is due one edge after phase 28, so the bench model updates its expected key at that same edge and compares on every falling edge from phase 29 onward. The bench changes key presses and force-open only in slot phases 4 to 20. That leaves the synchroniser and the column change fully settled before any sample, so each expected value is unambiguous.

// File: rtl/kms_pkg.sv
package kms_pkg;

  // Default geometry of the scanned matrix.
  localparam int DEF_COLS      = 16;
  localparam int DEF_ROWS      = 6;
  localparam int DEF_ROW_SKIP  = 2;
  localparam int DEF_SLOT_BITS = 5;

  // Default phases inside a key slot.
  localparam int DEF_RD_PHASE  = 1;
  localparam int DEF_SMP_PHASE = 28;
  localparam int DEF_WR_PHASE  = 30;

  // Timing strobes produced by the phase generator.
  typedef struct packed {
    logic rd;
    logic smp;
    logic wr;
  } kms_strobes_t;

endpackage

// File: rtl/kms_counter.sv
module kms_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_i,
  output logic [W-1:0] cnt_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) cnt_q <= '0;
    else       cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/kms_col_decode.sv
module kms_col_decode #(
  parameter int NUM_COLS = 16,
  parameter int COL_BITS = $clog2(NUM_COLS)
) (
  input  logic [COL_BITS-1:0] col_sel_i,
  output logic [NUM_COLS-1:0] col_o
);

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_o[c] = (col_sel_i == COL_BITS'(c));
  end

endmodule

// File: rtl/kms_phase_gen.sv
module kms_phase_gen
  import kms_pkg::*;
#(
  parameter int NUM_ROWS     = DEF_ROWS,
  parameter int ROW_SKIP     = DEF_ROW_SKIP,
  parameter int ROW_SEL_BITS = $clog2(NUM_ROWS + ROW_SKIP),
  parameter int SLOT_BITS    = DEF_SLOT_BITS,
  parameter int RD_PHASE     = DEF_RD_PHASE,
  parameter int SMP_PHASE    = DEF_SMP_PHASE,
  parameter int WR_PHASE     = DEF_WR_PHASE
) (
  input  logic [ROW_SEL_BITS-1:0] row_sel_i,
  input  logic [SLOT_BITS-1:0]    phase_i,
  output logic                    valid_o,
  output kms_strobes_t            stb_o
);

  localparam logic [ROW_SEL_BITS-1:0] ROW_LO = ROW_SEL_BITS'(ROW_SKIP);
  localparam logic [ROW_SEL_BITS:0]   ROW_HI = (ROW_SEL_BITS + 1)'(ROW_SKIP + NUM_ROWS);

  logic valid;

  // Lower row-select slots only give the row filters time to settle.
  assign valid   = (row_sel_i >= ROW_LO) && ({1'b0, row_sel_i} < ROW_HI);
  assign valid_o = valid;

  always_comb begin
    stb_o.rd  = valid && (phase_i == SLOT_BITS'(RD_PHASE));
    stb_o.wr  = valid && (phase_i == SLOT_BITS'(WR_PHASE));
    stb_o.smp = (phase_i == SLOT_BITS'(SMP_PHASE));
  end

endmodule

// File: rtl/kms_row_sample.sv
module kms_row_sample #(
  parameter int NUM_ROWS     = 6,
  parameter int ROW_SKIP     = 2,
  parameter int ROW_SEL_BITS = $clog2(NUM_ROWS + ROW_SKIP),
  parameter int SYNC_STAGES  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [NUM_ROWS-1:0]     rows_i,
  input  logic [ROW_SEL_BITS-1:0] row_sel_i,
  input  logic                    valid_i,
  input  logic                    smp_i,
  input  logic                    force_open_i,
  output logic                    key_o
);

  logic [NUM_ROWS-1:0] sync_q [SYNC_STAGES];
  logic [NUM_ROWS-1:0] rows_s;
  logic [ROW_SEL_BITS-1:0] rel;
  logic sel_bit;
  logic key_q;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q[s] <= '0;
        else       sync_q[s] <= rows_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (rst_i) sync_q[s] <= '0;
        else       sync_q[s] <= sync_q[s-1];
      end
    end
  end

  assign rows_s = sync_q[SYNC_STAGES-1];
  assign rel    = row_sel_i - ROW_SEL_BITS'(ROW_SKIP);

  always_comb begin
    sel_bit = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (rel == ROW_SEL_BITS'(r)) sel_bit = rows_s[r];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      key_q <= 1'b0;
    else if (smp_i) key_q <= valid_i && sel_bit && !force_open_i;
  end

  assign key_o = key_q;

endmodule

// File: rtl/keyscan_seq.sv
module keyscan_seq
  import kms_pkg::*;
#(
  parameter int NUM_COLS    = DEF_COLS,
  parameter int NUM_ROWS    = DEF_ROWS,
  parameter int ROW_SKIP    = DEF_ROW_SKIP,
  parameter int SLOT_BITS   = DEF_SLOT_BITS,
  parameter int RD_PHASE    = DEF_RD_PHASE,
  parameter int SMP_PHASE   = DEF_SMP_PHASE,
  parameter int WR_PHASE    = DEF_WR_PHASE,
  parameter int SYNC_STAGES = 2,
  localparam int COL_BITS     = $clog2(NUM_COLS),
  localparam int ROW_SEL_BITS = $clog2(NUM_ROWS + ROW_SKIP),
  localparam int CODE_BITS    = COL_BITS + ROW_SEL_BITS,
  localparam int CNT_BITS     = CODE_BITS + SLOT_BITS
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 force_open_i,
  input  logic [NUM_ROWS-1:0]  rows_i,
  output logic [NUM_COLS-1:0]  col_o,
  output logic [CODE_BITS-1:0] scancode_o,
  output logic                 slot_valid_o,
  output logic                 rd_stb_o,
  output logic                 wr_stb_o,
  output logic                 key_o
);

  logic [CNT_BITS-1:0]     cnt;
  logic [COL_BITS-1:0]     col_sel;
  logic [ROW_SEL_BITS-1:0] row_sel;
  logic [SLOT_BITS-1:0]    phase;
  logic                    valid;
  kms_strobes_t            stb;

  kms_counter #(.W(CNT_BITS)) u_cnt (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .cnt_o (cnt)
  );

  assign col_sel = cnt[CNT_BITS-1 -: COL_BITS];
  assign row_sel = cnt[SLOT_BITS +: ROW_SEL_BITS];
  assign phase   = cnt[SLOT_BITS-1:0];

  kms_col_decode #(.NUM_COLS(NUM_COLS), .COL_BITS(COL_BITS)) u_col (
    .col_sel_i (col_sel),
    .col_o     (col_o)
  );

  kms_phase_gen #(
    .NUM_ROWS(NUM_ROWS), .ROW_SKIP(ROW_SKIP), .ROW_SEL_BITS(ROW_SEL_BITS),
    .SLOT_BITS(SLOT_BITS), .RD_PHASE(RD_PHASE), .SMP_PHASE(SMP_PHASE),
    .WR_PHASE(WR_PHASE)
  ) u_phase (
    .row_sel_i (row_sel),
    .phase_i   (phase),
    .valid_o   (valid),
    .stb_o     (stb)
  );

  kms_row_sample #(
    .NUM_ROWS(NUM_ROWS), .ROW_SKIP(ROW_SKIP), .ROW_SEL_BITS(ROW_SEL_BITS),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_smp (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .rows_i       (rows_i),
    .row_sel_i    (row_sel),
    .valid_i      (valid),
    .smp_i        (stb.smp),
    .force_open_i (force_open_i),
    .key_o        (key_o)
  );

  assign scancode_o   = {col_sel, row_sel};
  assign slot_valid_o = valid;
  assign rd_stb_o     = stb.rd;
  assign wr_stb_o     = stb.wr;

endmodule

// File: rtl/kms_checker.sv
module kms_checker #(
  parameter int NUM_COLS  = 16,
  parameter int CNT_BITS  = 12,
  parameter int COL_BITS  = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                force_open_i,
  input logic [CNT_BITS-1:0] cnt,
  input logic [NUM_COLS-1:0] col_o,
  input logic                slot_valid_o,
  input logic                rd_stb_o,
  input logic                wr_stb_o,
  input logic                smp,
  input logic                key_o
);

  localparam int LOW_BITS = CNT_BITS - COL_BITS;

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    rst_i |=> (cnt == '0) && !key_o);

  assert_count_step_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> cnt == CNT_BITS'($past(cnt) + 1'b1));

  assert_col_onehot_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    $countones(col_o) == 1);

  assert_col_hold_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (cnt[LOW_BITS-1:0] != '1) |=> $stable(col_o));

  assert_stb_in_valid_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_stb_o || wr_stb_o) |-> slot_valid_o);

  assert_rd_single_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    rd_stb_o |=> !rd_stb_o);

  assert_stb_exclusive_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !(rd_stb_o && wr_stb_o));

  assert_invalid_open_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp && !slot_valid_o) |=> !key_o);

  assert_force_open_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (smp && force_open_i) |=> !key_o);

  assert_key_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    !smp |=> $stable(key_o));

endmodule

bind keyscan_seq kms_checker #(
  .NUM_COLS (NUM_COLS),
  .CNT_BITS (CNT_BITS),
  .COL_BITS (COL_BITS)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .force_open_i (force_open_i),
  .cnt          (cnt),
  .col_o        (col_o),
  .slot_valid_o (slot_valid_o),
  .rd_stb_o     (rd_stb_o),
  .wr_stb_o     (wr_stb_o),
  .smp          (stb.smp),
  .key_o        (key_o)
);

// File: tb/keyscan_seq_tb.sv
`timescale 1ns/1ps
module keyscan_seq_tb;

  localparam int NC = 16;
  localparam int NR = 6;
  localparam int NK = NC * NR;

  logic clk = 1'b0;
  logic rst;
  logic force_open;
  logic [NR-1:0] rows;
  logic [NC-1:0] col;
  logic [6:0] code;
  logic valid, rd, wr, key;

  logic [NK-1:0] keys;
  logic [11:0] exp_cnt;
  logic exp_key;
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyscan_seq u_dut (
    .clk_i(clk), .rst_i(rst), .force_open_i(force_open), .rows_i(rows),
    .col_o(col), .scancode_o(code), .slot_valid_o(valid),
    .rd_stb_o(rd), .wr_stb_o(wr), .key_o(key)
  );

  // Matrix model: a closed key connects the driven column to its row.
  always_comb begin
    rows = '0;
    for (int c = 0; c < NC; c++)
      for (int r = 0; r < NR; r++)
        if (col[c] && keys[c*NR + r]) rows[r] = 1'b1;
  end

  function automatic logic key_at(logic [6:0] sc, logic [NK-1:0] k, logic f);
    int rs = int'(sc[2:0]);
    if (rs < 2) return 1'b0;
    return k[int'(sc[6:3])*NR + rs - 2] & ~f;
  endfunction

  // Reference timing model.
  always @(posedge clk) begin
    if (rst) begin
      exp_cnt <= '0;
      exp_key <= 1'b0;
    end else begin
      exp_cnt <= exp_cnt + 1'b1;
      if (exp_cnt[4:0] == 5'd28) exp_key <= key_at(exp_cnt[11:5], keys, force_open);
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cnt=%0h)", req, act, expv, exp_cnt);
    end
  endtask

  task automatic cycle_checks();
    logic [4:0] ph = exp_cnt[4:0];
    logic [2:0] rs = exp_cnt[7:5];
    logic ev = (rs >= 3'd2);
    chk(code == exp_cnt[11:5], "R2 scancode", int'(code), int'(exp_cnt[11:5]));
    chk(col == (16'd1 << exp_cnt[11:8]), "R3 column", int'(col), int'(16'd1 << exp_cnt[11:8]));
    chk(valid == ev, "R4 slot valid", int'(valid), int'(ev));
    chk(rd == (ev && ph == 5'd1), "R5 read strobe", int'(rd), int'(ev && ph == 5'd1));
    chk(wr == (ev && ph == 5'd30), "R6 write strobe", int'(wr), int'(ev && ph == 5'd30));
    chk(key == exp_key, force_open ? "R8 key forced" : "R7 key sample", int'(key), int'(exp_key));
    if (wr) chk(key == key_at(code, keys, force_open), "R9 key at write", int'(key),
                int'(key_at(code, keys, force_open)));
  endtask

  task automatic check_reset_state();
    chk(code == 7'd0, "R1 scancode after reset", int'(code), 0);
    chk(col == 16'd1, "R1 column after reset", int'(col), 1);
    chk(key == 1'b0, "R1 key after reset", int'(key), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
  endtask

  // Runs n cycles; mode 0 keep, 1 random flips, 2 random force toggling too.
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycle_checks();
      if (exp_cnt[4:0] >= 5'd4 && exp_cnt[4:0] <= 5'd20) begin
        if (mode >= 1 && $urandom_range(0, 15) == 0)
          keys[$urandom_range(0, NK-1)] ^= 1'b1;
        if (mode == 2 && $urandom_range(0, 200) == 0)
          force_open = ~force_open;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    rst = 1'b1; force_open = 1'b0; keys = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_reset_state();
    run(4096, 0);                 // all open
    keys = '1;
    run(4096, 0);                 // all closed
    force_open = 1'b1;
    run(4096, 0);                 // R8: everything forced open
    force_open = 1'b0;
    keys = '0; keys[0*NR + 0] = 1'b1; keys[15*NR + 5] = 1'b1;
    run(4096, 0);                 // corner keys: first and last positions
    keys = {NK/2{2'b01}};
    run(4096 * 6, 1);             // random presses
    do_reset();                   // mid-run reset
    run(4096 * 6, 2);             // random presses with force toggling
    force_open = 1'b0;
    run(4096 * 2, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule